// File: doc/BRIEF.md
# Dual-Mode Oversampling Baud Tick Generator

This block turns a fast peripheral clock into the 16x oversampling strobe that a UART receiver and transmitter count on. A single 16-bit reload word sets the rate, and one mode input decides how that word is read.

In integer mode the word is a clock divisor, where divisor = f_clk / (16 x baud). The counter behind it suits slow rates below 19200 baud. In fractional mode the word is a phase increment, where increment = 16 x baud x 2^16 / f_clk. The increment is added to a 16-bit accumulator every clock, and each carry out of that accumulator is a tick. This gives the finer rate resolution needed at 19200 baud and above. For example, at 200 MHz an increment of about 604 gives 115200 baud.

A run input gates the generator. Software lowers run, sets the mode and reload, then raises run again. The generator captures the mode and reload at that rising edge and starts from a cleared counter or accumulator. While run stays high, changes on the mode and reload inputs are not used.

Top module: `baud_tick_gen`

## Requirements
- R1: A synchronous active-high reset forces os_tick to 0 on the following cycle and clears all state. If run_en is still high after reset is released, the generator treats that as a new start: the first active edge comes one cycle later.
- R2: A cycle edge at which run_en is sampled low leaves os_tick at 0 after that edge. The counter and accumulator are also held cleared.
- R3: In integer mode (frac_mode = 0) with reload N >= 2, os_tick pulses for one cycle on active edges j = 1, 1+N, 1+2N, and so on. Active edge 1 is the second consecutive edge at which run_en is sampled high.
- R4: In integer mode a reload of 0 or 1 makes os_tick high after every active edge.
- R5: In fractional mode (frac_mode = 1) with increment I, os_tick is high after active edge j exactly when floor(j*I/65536) > floor((j-1)*I/65536). This is the carry out of a 16-bit accumulator that starts at 0.
- R6: frac_mode and reload are captured only at the edge where run_en is first sampled high. Changes on those inputs while run_en stays high have no effect on os_tick.
- R7: In fractional mode an increment of 0 never produces a tick.
- R8: After run_en goes low and then high again, the tick pattern restarts from active edge 1 with cleared state, using the values captured at the new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Generator enable; its rising edge captures the settings |
| frac_mode | input | 1 | 0 = integer divisor, 1 = fractional increment |
| reload | input | 16 | Divisor or phase increment |
| os_tick | output | 1 | Registered single-cycle 16x oversample strobe |

## Verification
The hardest situation to reach is a change of reload and mode while the generator is running. From the ports it looks the same as a correct re-capture unless the old and new patterns differ clearly. The stimulus therefore starts an integer run with divisor 7, then switches the inputs to fractional mode with increment 3 while run stays high, and checks that the period-7 pattern continues. It then drops and raises run, and checks that the divisor of 3 takes over from a cleared state. A reset asserted in the middle of a fractional run, with run held high, covers the restart path through reset.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  localparam int BG_RELOAD_W = 16;

  typedef enum logic {
    BG_MODE_DIV  = 1'b0,
    BG_MODE_FRAC = 1'b1
  } bg_mode_e;

endpackage

// File: rtl/bg_run_ctrl.sv
module bg_run_ctrl #(
  parameter int W = baudgen_pkg::BG_RELOAD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_i,
  input  baudgen_pkg::bg_mode_e mode_i,
  input  logic [W-1:0]          reload_i,
  output logic                  active_o,
  output baudgen_pkg::bg_mode_e mode_o,
  output logic [W-1:0]          reload_o
);
  import baudgen_pkg::*;

  logic     run_d;
  bg_mode_e mode_q;
  logic [W-1:0] reload_q;
  logic     start;

  assign start    = run_i & ~run_d;
  assign active_o = run_i & run_d;
  assign mode_o   = mode_q;
  assign reload_o = reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_d    <= 1'b0;
      mode_q   <= BG_MODE_DIV;
      reload_q <= '0;
    end else begin
      run_d <= run_i;
      if (start) begin
        mode_q   <= mode_i;
        reload_q <= reload_i;
      end
    end
  end

  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (rst)
    active_o |=> ($stable(reload_q) && $stable(mode_q))); // R6

endmodule

// File: rtl/bg_div_engine.sv
module bg_div_engine #(
  parameter int W = baudgen_pkg::BG_RELOAD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q <= ONE);
  assign hit_o  = active_i & at_end;

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      cnt_q <= '0;
    end else if (at_end) begin
      cnt_q <= lim_i;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim_i); // R3
  AST_CNT_CLEARED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/bg_frac_engine.sv
module bg_frac_engine #(
  parameter int W = baudgen_pkg::BG_RELOAD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active_i,
  input  logic [W-1:0] inc_i,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, inc_i};
  assign carry_o = active_i & sum[W];

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      acc_q <= '0;
    end else begin
      acc_q <= sum[W-1:0];
    end
  end

  AST_ACC_CLEARED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (acc_q == '0)); // R8
  AST_ZERO_INC_SILENT: assert property (@(posedge clk) disable iff (rst)
    (inc_i == '0) |-> !carry_o); // R7

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RELOAD_W = baudgen_pkg::BG_RELOAD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_en,
  input  logic                frac_mode,
  input  logic [RELOAD_W-1:0] reload,
  output logic                os_tick
);
  import baudgen_pkg::*;

  logic          active;
  bg_mode_e      mode_q;
  logic [RELOAD_W-1:0] reload_q;
  logic          div_act, frac_act;
  logic          div_hit, frac_hit;

  bg_run_ctrl #(.W(RELOAD_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run_en),
    .mode_i   (bg_mode_e'(frac_mode)),
    .reload_i (reload),
    .active_o (active),
    .mode_o   (mode_q),
    .reload_o (reload_q)
  );

  assign div_act  = active & (mode_q == BG_MODE_DIV);
  assign frac_act = active & (mode_q == BG_MODE_FRAC);

  bg_div_engine #(.W(RELOAD_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .active_i (div_act),
    .lim_i    (reload_q),
    .hit_o    (div_hit)
  );

  bg_frac_engine #(.W(RELOAD_W)) u_frac (
    .clk      (clk),
    .rst      (rst),
    .active_i (frac_act),
    .inc_i    (reload_q),
    .carry_o  (frac_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      os_tick <= 1'b0;
    end else begin
      os_tick <= div_hit | frac_hit;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !os_tick); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !os_tick); // R2
  AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (rst)
    !(div_hit && frac_hit)); // R5

endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        frac_mode = 1'b0;
  logic [15:0] reload = '0;
  logic        os_tick;

  item_t sb_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  // bench model state
  bit          rd_m = 1'b0;
  longint      j_m = 0;
  bit          mode_m = 1'b0;
  longint      lim_m = 0;

  baud_tick_gen u0 (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .frac_mode (frac_mode),
    .reload    (reload),
    .os_tick   (os_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input bit rs, input bit r, input bit m,
                      input logic [15:0] rl, input string ovr);
    bit    e;
    string t;
    @(negedge clk);
    rst = rs; run_en = r; frac_mode = m; reload = rl;
    e = 1'b0;
    if (rs) begin
      rd_m = 1'b0; j_m = 0; t = "R1";
    end else begin
      if (rd_m && r) begin
        j_m++;
        if (!mode_m) begin
          e = (lim_m <= 1) ? 1'b1 : (((j_m - 1) % lim_m) == 0);
          t = (lim_m <= 1) ? "R4" : "R3";
        end else begin
          e = ((j_m * lim_m) >> 16) != (((j_m - 1) * lim_m) >> 16);
          t = (lim_m == 0) ? "R7" : "R5";
        end
      end else begin
        j_m = 0; t = "R2";
      end
      if (r && !rd_m) begin
        mode_m = m; lim_m = longint'(rl);
      end
      rd_m = r;
    end
    if (ovr != "") t = ovr;
    sb_q.push_back('{exp: e, tag: t});
  endtask

  task automatic run_for(input int n, input bit rs, input bit r, input bit m,
                         input logic [15:0] rl, input string ovr);
    for (int i = 0; i < n; i++) step(rs, r, m, rl, ovr);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (os_tick !== it.exp) begin
          errors++;
          $display("FAIL %s: os_tick actual=%b expected=%b at %0t",
                   it.tag, os_tick, it.exp, $time);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    run_for(3, 1'b1, 1'b0, 1'b0, 16'd0, "R1");          // reset state
    run_for(4, 1'b0, 1'b0, 1'b0, 16'd5, "R2");          // idle
    run_for(40, 1'b0, 1'b1, 1'b0, 16'd5, "");           // R3 divisor 5
    run_for(3, 1'b0, 1'b0, 1'b0, 16'd1, "R2");          // stop
    run_for(20, 1'b0, 1'b1, 1'b0, 16'd1, "");           // R4 divisor 1
    run_for(2, 1'b0, 1'b0, 1'b0, 16'd0, "R2");
    run_for(20, 1'b0, 1'b1, 1'b0, 16'd0, "");           // R4 divisor 0
    run_for(2, 1'b0, 1'b0, 1'b0, 16'd7, "R2");
    run_for(10, 1'b0, 1'b1, 1'b0, 16'd7, "");           // R3 divisor 7
    run_for(30, 1'b0, 1'b1, 1'b1, 16'd3, "R6");         // inputs change mid-run
    run_for(2, 1'b0, 1'b0, 1'b0, 16'd3, "R2");
    run_for(20, 1'b0, 1'b1, 1'b0, 16'd3, "R8");         // restart picks up 3
    run_for(2, 1'b0, 1'b0, 1'b1, 16'd20000, "R2");
    run_for(300, 1'b0, 1'b1, 1'b1, 16'd20000, "");      // R5
    run_for(2, 1'b0, 1'b0, 1'b1, 16'd604, "R2");
    run_for(600, 1'b0, 1'b1, 1'b1, 16'd604, "");        // R5 ~115200 baud
    run_for(2, 1'b0, 1'b0, 1'b1, 16'd65535, "R2");
    run_for(50, 1'b0, 1'b1, 1'b1, 16'd65535, "");       // R5 near-full rate
    run_for(2, 1'b0, 1'b0, 1'b1, 16'd0, "R2");
    run_for(50, 1'b0, 1'b1, 1'b1, 16'd0, "");           // R7
    run_for(2, 1'b0, 1'b0, 1'b1, 16'd30000, "R2");
    run_for(20, 1'b0, 1'b1, 1'b1, 16'd30000, "");       // R5
    run_for(2, 1'b1, 1'b1, 1'b1, 16'd30000, "R1");      // reset while running
    run_for(30, 1'b0, 1'b1, 1'b1, 16'd30000, "R1");     // restart after reset
    run_for(3, 1'b0, 1'b0, 1'b0, 16'd0, "R2");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule